// File: doc/BRIEF.md
# Dual-Channel LVDS Route Bridge

This block links two parallel video sources and two LVDS transmit channels. Each source delivers a 24-bit pixel with horizontal sync, vertical sync and a data-enable strobe, all in one pixel clock domain. For every pixel, each output channel delivers four 7-bit data lane words and a 7-bit clock lane word. These are meant for a following 7:1 serializer. The serializer, the analog driver and clock generation sit outside this block.

A 32-bit control word, loaded through a single write strobe and readable back, sets three things. First, where each channel takes its pixels from: off, the first source or the second source. Second, whether the two channels split one source: even pixels of a line go to channel 0 and odd pixels to channel 1, so each channel runs at half rate and the serializer runs at 3.5 times the pixel rate instead of 7 times. Third, per channel, the colour depth (18 or 24 bit) and the lane bit ordering, plus the vertical sync polarity of each source. When both channels take the same source without splitting, they carry the same picture.

Top module: `lvds_route_bridge`

## Requirements
- R1: Control bits [1:0] route channel 0 and bits [3:2] route channel 1. With the low bit of a field at 0 (codes 00 and 10) the channel is off. Code 01 takes the first source (di0) and 11 takes the second (di1). A routed pixel appears on the channel outputs one clock after it is presented.
- R2: A channel that is off drives all data lanes to zero, its clock lane word to zero and its valid low.
- R3: An enabled channel outside split mode raises valid on every clock and carries the clock lane word 1100011. Data lane k sits in bits [7k+6:7k] of the channel's data port.
- R4: Pixel layout is R in bits 23:16, G in 15:8 and B in 7:0. Each colour has a 6-bit core and a 2-bit extension. Within a lane word, bit 6 is sent first. Lane 0 is {G core[0], R core[5:0]}. Lane 1 is {B core[1:0], G core[5:1]}. Lane 2 is {DE, VS, HS, B core[5:2]}. Lane 3 is {0, B ext, G ext, R ext}.
- R5: Bit 5 (channel 0) and bit 7 (channel 1) set colour depth, 1 for 24 bit and 0 for 18 bit. At 18 bit the core is colour[7:2] and lane 3 is all zero.
- R6: Bit 6 (channel 0) and bit 8 (channel 1) pick the 24-bit ordering. With 0, the core is colour[5:0] and the extension is colour[7:6]. With 1, the core is colour[7:2] and the extension is colour[1:0].
- R7: Bit 9 (di0) and bit 10 (di1) mark the source's vertical sync as active low. The VS bit sent is the input XOR this bit, so it is always active high on the link.
- R8: Both channels enabled from the same source, split off, with equal depth and ordering, carry identical data words.
- R9: Split mode is bit 4, with both channels enabled from one source. The first DE-high cycle after DE low is an even pixel, and pixels then alternate even and odd. One clock after each odd pixel, channel 0 presents the preceding even pixel and channel 1 the odd one, both valid. On the other clocks, valid is low and the words hold.
- R10: Bit 4 has no effect unless both channels are enabled from the same source. Otherwise each channel behaves as in R1 and R3.
- R11: A write applies to pixels presented from the next clock on. Readback returns bits [10:0] as written, with bits [31:11] reading zero. After reset the register is zero.
- R12: Writing zero to the control register turns both channels off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register readback |
| di0_pix | input | 24 | First source pixel {R,G,B} |
| di0_hs | input | 1 | First source horizontal sync |
| di0_vs | input | 1 | First source vertical sync |
| di0_de | input | 1 | First source data enable |
| di1_pix | input | 24 | Second source pixel {R,G,B} |
| di1_hs | input | 1 | Second source horizontal sync |
| di1_vs | input | 1 | Second source vertical sync |
| di1_de | input | 1 | Second source data enable |
| ch0_data | output | 28 | Channel 0 data lane words, lane k at [7k+6:7k] |
| ch0_clk | output | 7 | Channel 0 clock lane word |
| ch0_valid | output | 1 | Channel 0 word valid |
| ch1_data | output | 28 | Channel 1 data lane words |
| ch1_clk | output | 7 | Channel 1 clock lane word |
| ch1_valid | output | 1 | Channel 1 word valid |

## Verification
The two sources are driven with different asymmetric pixels and sync patterns. A word that comes from the wrong source, or that has swapped colour bytes, therefore cannot match by chance. Settings are swept over duplicate, crossed and independent routing, both depths, both orderings and both polarities. These show apart a wrong lane position, a wrong core or extension slice, and a wrong polarity. A split run over two pixel pairs shows whether the even and odd pixels are steered correctly and whether the output is held between pairs. Split requested with mismatched routing, the 10 routing code, and a write in the same cycle as a pixel each check one rule about when a setting takes effect.

// File: rtl/lvds_route_pkg.sv
package lvds_route_pkg;
  localparam int LANE_W     = 7;
  localparam int DATA_LANES = 4;
  localparam int COLOR_W    = 8;
  localparam int CORE_W     = COLOR_W - 2;
  localparam int PIX_W      = 3 * COLOR_W;
  localparam int WORD_W     = LANE_W * DATA_LANES;
  localparam int CFG_W      = 32;
  localparam int CFG_USED   = 11;
  localparam logic [LANE_W-1:0] CLK_LANE_PAT = 7'b1100011;

  typedef struct packed {
    logic [PIX_W-1:0] pix;
    logic             hs;
    logic             vs;
    logic             de;
  } vid_t;

  typedef struct packed {
    logic [1:0] route;
    logic       wide;
    logic       jeida;
  } chan_cfg_t;

  typedef struct packed {
    chan_cfg_t [1:0] ch;
    logic            split;
    logic [1:0]      vs_low;
  } cfg_t;

  function automatic cfg_t cfg_decode(logic [CFG_W-1:0] r);
    cfg_t c;
    c.ch[0].route = r[1:0];
    c.ch[1].route = r[3:2];
    c.split       = r[4];
    c.ch[0].wide  = r[5];
    c.ch[0].jeida = r[6];
    c.ch[1].wide  = r[7];
    c.ch[1].jeida = r[8];
    c.vs_low      = r[10:9];
    return c;
  endfunction

  function automatic logic route_on(logic [1:0] r);
    return r[0];
  endfunction

  function automatic logic route_src(logic [1:0] r);
    return r[1];
  endfunction

  function automatic logic [CORE_W-1:0] core_bits(logic [COLOR_W-1:0] c, logic wide, logic jeida);
    return (wide && !jeida) ? c[CORE_W-1:0] : c[COLOR_W-1:2];
  endfunction

  function automatic logic [1:0] ext_bits(logic [COLOR_W-1:0] c, logic wide, logic jeida);
    if (!wide)  return 2'b00;
    if (jeida)  return c[1:0];
    return c[COLOR_W-1:COLOR_W-2];
  endfunction

  function automatic logic [WORD_W-1:0] pack_lanes(vid_t v, logic wide, logic jeida);
    logic [COLOR_W-1:0] r, g, b;
    logic [CORE_W-1:0]  r6, g6, b6;
    logic [1:0]         r2, g2, b2;
    logic [LANE_W-1:0]  l0, l1, l2, l3;
    r  = v.pix[PIX_W-1 -: COLOR_W];
    g  = v.pix[2*COLOR_W-1 -: COLOR_W];
    b  = v.pix[COLOR_W-1:0];
    r6 = core_bits(r, wide, jeida);
    g6 = core_bits(g, wide, jeida);
    b6 = core_bits(b, wide, jeida);
    r2 = ext_bits(r, wide, jeida);
    g2 = ext_bits(g, wide, jeida);
    b2 = ext_bits(b, wide, jeida);
    l0 = {g6[0], r6};
    l1 = {b6[1:0], g6[5:1]};
    l2 = {v.de, v.vs, v.hs, b6[5:2]};
    l3 = {1'b0, b2, g2, r2};
    return {l3, l2, l1, l0};
  endfunction
endpackage

// File: rtl/lvds_cfg_reg.sv
module lvds_cfg_reg
  import lvds_route_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output cfg_t             cfg
);
  localparam logic [CFG_W-1:0] USED_MASK = CFG_W'((64'd1 << CFG_USED) - 64'd1);

  logic [CFG_W-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctrl_q <= '0;
    else if (we) ctrl_q <= wdata & USED_MASK;
  end

  assign rdata = ctrl_q;
  assign cfg   = cfg_decode(ctrl_q);

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(rdata)); // R11
endmodule

// File: rtl/lvds_split_pairer.sv
module lvds_split_pairer
  import lvds_route_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic split_on,
  input  vid_t cur,
  output vid_t held,
  output logic emit
);
  logic de_q, phase_q;
  vid_t hold_q;
  logic de_rise, odd_phase;

  assign de_rise   = cur.de & ~de_q;
  assign odd_phase = de_rise ? 1'b0 : phase_q;
  assign emit      = split_on & odd_phase;
  assign held      = hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_q    <= 1'b0;
      phase_q <= 1'b0;
      hold_q  <= '0;
    end else if (!split_on) begin
      de_q    <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      de_q    <= cur.de;
      phase_q <= ~odd_phase;
      if (!odd_phase) hold_q <= cur;
    end
  end

  AST_EMIT_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    emit |=> !emit); // R9
endmodule

// File: rtl/lvds_chan_out.sv
module lvds_chan_out
  import lvds_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              split_on,
  input  logic              emit,
  input  logic              wide,
  input  logic              jeida,
  input  vid_t              src,
  output logic [WORD_W-1:0] data,
  output logic [LANE_W-1:0] clkw,
  output logic              valid
);
  logic [WORD_W-1:0] word;
  logic              load;

  assign word = pack_lanes(src, wide, jeida);
  assign load = en & (~split_on | emit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data  <= '0;
      clkw  <= '0;
      valid <= 1'b0;
    end else if (!en) begin
      data  <= '0;
      clkw  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= load;
      if (load) begin
        data <= word;
        clkw <= CLK_LANE_PAT;
      end
    end
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (data == '0 && clkw == '0 && !valid)); // R2
  AST_CLK_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> clkw == CLK_LANE_PAT); // R3
  AST_NARROW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wide) |=> data[WORD_W-1 -: LANE_W] == '0); // R5
endmodule

// File: rtl/lvds_route_bridge.sv
module lvds_route_bridge
  import lvds_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic [PIX_W-1:0]  di0_pix,
  input  logic              di0_hs,
  input  logic              di0_vs,
  input  logic              di0_de,
  input  logic [PIX_W-1:0]  di1_pix,
  input  logic              di1_hs,
  input  logic              di1_vs,
  input  logic              di1_de,
  output logic [WORD_W-1:0] ch0_data,
  output logic [LANE_W-1:0] ch0_clk,
  output logic              ch0_valid,
  output logic [WORD_W-1:0] ch1_data,
  output logic [LANE_W-1:0] ch1_clk,
  output logic              ch1_valid
);
  localparam int NUM_CH = 2;

  cfg_t cfg;
  vid_t in_vid [NUM_CH];
  vid_t held_vid;
  logic split_eff, emit;
  logic split_src;
  logic [WORD_W-1:0] data_o [NUM_CH];
  logic [LANE_W-1:0] clk_o  [NUM_CH];
  logic              vld_o  [NUM_CH];

  lvds_cfg_reg cfg_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .cfg(cfg)
  );

  // vertical sync normalised to active high before routing
  assign in_vid[0] = '{pix: di0_pix, hs: di0_hs, vs: di0_vs ^ cfg.vs_low[0], de: di0_de};
  assign in_vid[1] = '{pix: di1_pix, hs: di1_hs, vs: di1_vs ^ cfg.vs_low[1], de: di1_de};

  assign split_src = route_src(cfg.ch[0].route);
  assign split_eff = cfg.split
                   & route_on(cfg.ch[0].route) & route_on(cfg.ch[1].route)
                   & (route_src(cfg.ch[0].route) == route_src(cfg.ch[1].route));

  lvds_split_pairer pair_i (
    .clk(clk), .rst_n(rst_n), .split_on(split_eff),
    .cur(in_vid[split_src]), .held(held_vid), .emit(emit)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    vid_t src_vid;
    if (g == 0) begin : g_even
      assign src_vid = split_eff ? held_vid : in_vid[route_src(cfg.ch[g].route)];
    end else begin : g_odd
      assign src_vid = split_eff ? in_vid[split_src] : in_vid[route_src(cfg.ch[g].route)];
    end

    lvds_chan_out out_i (
      .clk(clk), .rst_n(rst_n),
      .en(route_on(cfg.ch[g].route)), .split_on(split_eff), .emit(emit),
      .wide(cfg.ch[g].wide), .jeida(cfg.ch[g].jeida), .src(src_vid),
      .data(data_o[g]), .clkw(clk_o[g]), .valid(vld_o[g])
    );
  end

  assign ch0_data  = data_o[0];
  assign ch0_clk   = clk_o[0];
  assign ch0_valid = vld_o[0];
  assign ch1_data  = data_o[1];
  assign ch1_clk   = clk_o[1];
  assign ch1_valid = vld_o[1];

  AST_DUP_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (route_on(cfg.ch[0].route) && route_on(cfg.ch[1].route) && !cfg.split
     && cfg.ch[0].route == cfg.ch[1].route
     && cfg.ch[0].wide == cfg.ch[1].wide && cfg.ch[0].jeida == cfg.ch[1].jeida)
    |=> ch0_data == ch1_data); // R8
  AST_SPLIT_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    split_eff |=> ch0_valid == ch1_valid); // R9
endmodule

// File: tb/lvds_route_bridge_tb_top.sv
module lvds_route_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam logic [6:0] PAT = 7'b1100011;

  localparam logic [31:0] V_CFG [NV] = '{32'h005, 32'h0AF, 32'h06D, 32'h187,
                                         32'h08E, 32'h6AD, 32'h20D, 32'h011};
  localparam logic [23:0] V_P0  [NV] = '{24'hC3A55A, 24'h123456, 24'h81C37E, 24'hA0B0C0,
                                         24'h0F1E2D, 24'hFEDCBA, 24'h55AA33, 24'h9D2E47};
  localparam logic [23:0] V_P1  [NV] = '{24'h3C5AA5, 24'hE7F018, 24'h7E18E7, 24'h13579B,
                                         24'hD2C1B0, 24'h2468AC, 24'hCC0F3F, 24'h61B8F2};
  // {hs0, vs0, de0, hs1, vs1, de1}
  localparam logic [5:0]  V_SYN [NV] = '{6'b001_011, 6'b101_001, 6'b011_111, 6'b111_100,
                                         6'b010_101, 6'b011_001, 6'b011_110, 6'b101_011};
  localparam string       V_TAG [NV] = '{"R8", "R8", "R6", "R5", "R1", "R7", "R7", "R10"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [23:0] di0_pix = '0, di1_pix = '0;
  logic        di0_hs = 0, di0_vs = 0, di0_de = 0;
  logic        di1_hs = 0, di1_vs = 0, di1_de = 0;
  logic [27:0] ch0_data, ch1_data;
  logic [6:0]  ch0_clk, ch1_clk;
  logic        ch0_valid, ch1_valid;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvds_route_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .di0_pix(di0_pix), .di0_hs(di0_hs), .di0_vs(di0_vs), .di0_de(di0_de),
    .di1_pix(di1_pix), .di1_hs(di1_hs), .di1_vs(di1_vs), .di1_de(di1_de),
    .ch0_data(ch0_data), .ch0_clk(ch0_clk), .ch0_valid(ch0_valid),
    .ch1_data(ch1_data), .ch1_clk(ch1_clk), .ch1_valid(ch1_valid)
  );

  // independent lane model, built bit by bit
  function automatic logic [27:0] lanes_exp(logic [23:0] px, logic hs, logic vs, logic de,
                                            logic wide, logic jeida);
    logic [27:0] w;
    logic [7:0]  col [3];
    logic [5:0]  cr  [3];
    logic [1:0]  ex  [3];
    col[0] = px[23:16]; col[1] = px[15:8]; col[2] = px[7:0];
    for (int k = 0; k < 3; k++) begin
      if (!wide)      begin cr[k] = 6'(col[k] >> 2); ex[k] = 2'b00; end
      else if (jeida) begin cr[k] = 6'(col[k] >> 2); ex[k] = col[k][1:0]; end
      else            begin cr[k] = col[k][5:0];     ex[k] = 2'(col[k] >> 6); end
    end
    w = '0;
    for (int i = 0; i < 6; i++) w[i] = cr[0][i];
    w[6] = cr[1][0];
    for (int i = 1; i < 6; i++) w[6+i] = cr[1][i];
    w[12] = cr[2][0];
    w[13] = cr[2][1];
    for (int i = 2; i < 6; i++) w[12+i] = cr[2][i];
    w[18] = hs; w[19] = vs; w[20] = de;
    w[22:21] = ex[0]; w[24:23] = ex[1]; w[26:25] = ex[2];
    return w;
  endfunction

  function automatic logic [27:0] chan_exp(logic [31:0] c, int g, logic [23:0] p0, logic [2:0] s0,
                                           logic [23:0] p1, logic [2:0] s1);
    logic [1:0] rt;
    logic wide, jeida;
    rt    = (g == 0) ? c[1:0] : c[3:2];
    wide  = (g == 0) ? c[5] : c[7];
    jeida = (g == 0) ? c[6] : c[8];
    if (!rt[0]) return '0;
    if (rt[1]) return lanes_exp(p1, s1[2], s1[1] ^ c[10], s1[0], wide, jeida);
    return lanes_exp(p0, s0[2], s0[1] ^ c[9], s0[0], wide, jeida);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_cfg(logic [31:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic drive(logic [23:0] p0, logic [2:0] s0, logic [23:0] p1, logic [2:0] s1);
    di0_pix = p0; {di0_hs, di0_vs, di0_de} = s0;
    di1_pix = p1; {di1_hs, di1_vs, di1_de} = s1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [27:0] a_w, b_w, c_w, d_w;
    @(negedge clk);
    tick(); tick();
    // R11 reset state
    chk("R11 reset readback", cfg_rdata, 32'h0);
    chk("R2 reset ch0 valid", {31'b0, ch0_valid}, 32'h0);
    chk("R2 reset ch1 clock lane", {25'b0, ch1_clk}, 32'h0);
    rst_n = 1'b1;
    tick();

    // vector walk
    for (int i = 0; i < NV; i++) begin
      write_cfg(V_CFG[i]);
      drive(V_P0[i], V_SYN[i][5:3], V_P1[i], V_SYN[i][2:0]);
      tick();
      chk({V_TAG[i], " R4 ch0 data"}, {4'b0, ch0_data},
          {4'b0, chan_exp(V_CFG[i], 0, V_P0[i], V_SYN[i][5:3], V_P1[i], V_SYN[i][2:0])});
      chk({V_TAG[i], " R4 ch1 data"}, {4'b0, ch1_data},
          {4'b0, chan_exp(V_CFG[i], 1, V_P0[i], V_SYN[i][5:3], V_P1[i], V_SYN[i][2:0])});
      chk("R1 ch0 valid", {31'b0, ch0_valid}, {31'b0, V_CFG[i][0]});
      chk("R1 ch1 valid", {31'b0, ch1_valid}, {31'b0, V_CFG[i][2]});
      chk("R3 ch0 clock lane", {25'b0, ch0_clk}, V_CFG[i][0] ? {25'b0, PAT} : 32'h0);
      chk("R2 R3 ch1 clock lane", {25'b0, ch1_clk}, V_CFG[i][2] ? {25'b0, PAT} : 32'h0);
    end

    // R11 readback mask
    write_cfg(32'hFFFF_FFFF);
    chk("R11 reserved bits read zero", cfg_rdata, 32'h0000_07FF);

    // R12 zero write disables both
    write_cfg(32'h0);
    drive(24'hABCDEF, 3'b111, 24'h456789, 3'b111);
    tick();
    chk("R12 ch0 data after zero", {4'b0, ch0_data}, 32'h0);
    chk("R12 ch1 valid after zero", {31'b0, ch1_valid}, 32'h0);
    chk("R2 ch0 clock lane off", {25'b0, ch0_clk}, 32'h0);

    // R11 write applies from the next pixel
    cfg_we = 1'b1; cfg_wdata = 32'h005;
    drive(24'h314159, 3'b001, 24'h0, 3'b000);
    tick();
    cfg_we = 1'b0;
    chk("R11 same-cycle pixel uses old setting", {31'b0, ch0_valid}, 32'h0);
    tick();
    chk("R11 next pixel uses new setting", {4'b0, ch0_data},
        {4'b0, lanes_exp(24'h314159, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0)});

    // R9 split from the second source, both 24-bit ordering 0
    drive(24'h0, 3'b000, 24'h0, 3'b000);
    write_cfg(32'h0BF);
    tick();
    drive(24'h0, 3'b000, 24'h1A2B3C, 3'b101);
    tick();
    chk("R9 even pixel no valid", {31'b0, ch0_valid}, 32'h0);
    drive(24'h0, 3'b000, 24'hD4E5F6, 3'b011);
    tick();
    a_w = lanes_exp(24'h1A2B3C, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    b_w = lanes_exp(24'hD4E5F6, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R9 pair ch0 even pixel", {4'b0, ch0_data}, {4'b0, a_w});
    chk("R9 pair ch1 odd pixel", {4'b0, ch1_data}, {4'b0, b_w});
    chk("R9 pair both valid", {30'b0, ch0_valid, ch1_valid}, 32'h3);
    drive(24'h0, 3'b000, 24'h778899, 3'b001);
    tick();
    chk("R9 between pairs no valid", {30'b0, ch0_valid, ch1_valid}, 32'h0);
    chk("R9 words hold between pairs", {4'b0, ch1_data}, {4'b0, b_w});
    drive(24'h0, 3'b000, 24'h0066CC, 3'b001);
    tick();
    c_w = lanes_exp(24'h778899, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    d_w = lanes_exp(24'h0066CC, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R9 second pair ch0", {4'b0, ch0_data}, {4'b0, c_w});
    chk("R9 second pair ch1", {4'b0, ch1_data}, {4'b0, d_w});

    // R10 split ignored with different sources
    write_cfg(32'h01D);
    drive(24'h102030, 3'b001, 24'h405060, 3'b001);
    tick();
    chk("R10 ch0 own source", {4'b0, ch0_data},
        {4'b0, lanes_exp(24'h102030, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0)});
    drive(24'h708090, 3'b001, 24'hA0B0C0, 3'b001);
    tick();
    chk("R10 valid every cycle", {30'b0, ch0_valid, ch1_valid}, 32'h3);
    chk("R10 ch1 own source", {4'b0, ch1_data},
        {4'b0, lanes_exp(24'hA0B0C0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0)});

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule